// File: doc/BRIEF.md
# Misaligned Access Detector and Splicer

This unit sits between the execution stage and a 32-bit word-addressed memory. Every load, store, jump and return-from-trap request passes through it. It compares the low address bits with the access size. An offending request either raises an alignment trap with trap type 0x07, or, when fix-up mode is on and the case can be repaired, it is completed without a trap.

Two cases can be repaired. A misaligned word load is split into two aligned word reads: first the word that holds the start address, then the next word. The wanted four bytes are then spliced out of the pair in big-endian order. A misaligned control-transfer target has its two low bits cleared and is returned as the result.

Aligned accesses go to memory as one beat, or as two beats for a doubleword, and add no wait beyond the memory acknowledge. One request is in flight at a time.

Top module: `align_unit`

## Requirements
- R1: Encodings are req_size 0 byte, 1 halfword, 2 word, 3 doubleword, and req_kind 0 load, 1 store, 2 jump, 3 return-from-trap. For loads and stores, a halfword with address bit 0 set is misaligned. So is a word with either of bits 1:0 set, and a doubleword with any of bits 2:0 set. A byte is never misaligned.
- R2: A jump or return-from-trap target is misaligned when its address bits 1:0 are not both zero, whatever req_size is.
- R3: A misaligned request that is not repaired pulses trap for one cycle, in the cycle after acceptance, with trap_type 0x07. It issues no mem_req and gives no res_valid.
- R4: With fix_en high, a misaligned word load with k = address mod 4 reads the word at address with bits 1:0 cleared, then the word 4 bytes above it. res_data[31:0] is (w0 << 8k) | (w1 >> 8(4-k)). For memory bytes 12 34 56 78 9a bc de f0 at address 0, a word load at 1 returns 0x3456789a.
- R5: With fix_en high, a misaligned jump or return-from-trap gives no trap and no memory access. res_data is the target with bits 1:0 cleared. An aligned target is returned unchanged.
- R6: Fix-up mode repairs nothing else. Misaligned halfword loads, doubleword loads and all misaligned stores trap even with fix_en high.
- R7: An aligned load of byte, halfword or word makes one read of the containing word. Byte offset k is taken from bits 31-8k downward (big-endian) and zero-extended. res_valid rises in the cycle after the memory acknowledge.
- R8: An aligned doubleword load reads the word at the address and then the word 4 above. res_data is {first, second}.
- R9: Stores drive mem_we high. mem_be bit 3 selects memory bits 31:24, and a byte store at offset k sets only bit 3-k. A halfword store at offset k sets bits 3-k and 2-k. The data sits in the matching lanes. A doubleword store writes req_wdata[63:32] and then req_wdata[31:0] to consecutive words.
- R10: req_ready is high only when idle. A request presented while busy is ignored and never accepted later unless still presented. res_valid lasts exactly one cycle.
- R11: After reset, req_ready is 1 and mem_req, trap and res_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fix_en | input | 1 | Enables repair of misaligned word loads and jump targets |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_addr | input | AW | Byte address or jump target |
| req_size | input | 2 | Access size code |
| req_kind | input | 2 | Access kind code |
| req_wdata | input | 64 | Store data, right-aligned; doubleword uses all 64 bits |
| mem_req | output | 1 | Memory beat request, held until acknowledged |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW | Word-aligned beat address |
| mem_be | output | 4 | Byte lane enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Write data for the beat |
| mem_rvalid | input | 1 | Beat acknowledge, with read data |
| mem_rdata | input | 32 | Read data |
| trap | output | 1 | Alignment trap pulse |
| trap_type | output | 8 | Trap type, 0x07 while trap is high |
| res_valid | output | 1 | Result strobe |
| res_data | output | 64 | Load data or jump target |

## Verification
The hardest state to reach is a request arriving while a two-beat splice is waiting on a slow memory. The bench makes the memory acknowledge late, then presents a conflicting store during both beats. It checks that the store never reaches memory and that the spliced word is still correct. Every offset of the misaligned word load, 1, 2 and 3, is spliced across a word boundary and compared with bytes the bench computes from its own memory image.

// File: rtl/align_pkg.sv
package align_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned OFS_W  = $clog2(LANES);
  localparam int unsigned SHW    = $clog2(WORD_W) + 1;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_DWORD = 2'd3} acc_size_e;
  typedef enum logic [1:0] {K_LOAD = 2'd0, K_STORE = 2'd1, K_JUMP = 2'd2, K_RETT = 2'd3} acc_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_BEAT0, ST_BEAT1, ST_DONE} seq_state_e;

  typedef struct packed {
    logic misaligned;
    logic fixable;
    logic two_beats;
    logic uses_mem;
  } chk_res_t;
endpackage

// File: rtl/align_check.sv
module align_check
  import align_pkg::*;
(
  input  logic [2:0] addr_lo,
  input  acc_size_e  size,
  input  acc_kind_e  kind,
  input  logic       fix_en,
  output chk_res_t   res
);
  logic is_xfer;
  logic mis;

  always_comb begin
    is_xfer = (kind == K_JUMP) || (kind == K_RETT);
    if (is_xfer) begin
      mis = |addr_lo[1:0];
    end else begin
      case (size)
        SZ_BYTE: mis = 1'b0;
        SZ_HALF: mis = addr_lo[0];
        SZ_WORD: mis = |addr_lo[1:0];
        default: mis = |addr_lo;
      endcase
    end
    res.misaligned = mis;
    res.fixable    = fix_en && mis && (is_xfer || (kind == K_LOAD && size == SZ_WORD));
    res.uses_mem   = !is_xfer;
    res.two_beats  = !is_xfer && ((size == SZ_DWORD) || (mis && kind == K_LOAD && size == SZ_WORD));
  end
endmodule

// File: rtl/align_merge.sv
module align_merge
  import align_pkg::*;
(
  input  logic [WORD_W-1:0]   w0,
  input  logic [WORD_W-1:0]   w1,
  input  acc_size_e           size,
  input  logic [OFS_W-1:0]    ofs,
  output logic [2*WORD_W-1:0] data
);
  logic [SHW-1:0]    amt0;
  logic [SHW-1:0]    amt1;
  logic [WORD_W-1:0] sh0;
  logic [WORD_W-1:0] sh1;

  always_comb begin
    amt0 = SHW'({ofs, 3'b000});
    amt1 = SHW'(WORD_W) - amt0;
    sh0  = w0 << amt0;
    sh1  = (ofs == '0) ? '0 : (w1 >> amt1);
    case (size)
      SZ_BYTE:  data = {{(2*WORD_W-8){1'b0}},  sh0[WORD_W-1 -: 8]};
      SZ_HALF:  data = {{(2*WORD_W-16){1'b0}}, sh0[WORD_W-1 -: 16]};
      SZ_WORD:  data = {{WORD_W{1'b0}}, sh0 | sh1};
      default:  data = {w0, w1};
    endcase
  end
endmodule

// File: rtl/align_lanes.sv
module align_lanes
  import align_pkg::*;
(
  input  logic [2*WORD_W-1:0] wdata,
  input  acc_size_e           size,
  input  logic [OFS_W-1:0]    ofs,
  input  logic                beat,
  output logic [WORD_W-1:0]   lane_data,
  output logic [LANES-1:0]    lane_be
);
  localparam logic [LANES-1:0] TOP1 = {1'b1,  {(LANES-1){1'b0}}};
  localparam logic [LANES-1:0] TOP2 = {2'b11, {(LANES-2){1'b0}}};

  always_comb begin
    case (size)
      SZ_BYTE: begin
        lane_data = {LANES{wdata[7:0]}};
        lane_be   = TOP1 >> ofs;
      end
      SZ_HALF: begin
        lane_data = {(LANES/2){wdata[15:0]}};
        lane_be   = TOP2 >> ofs;
      end
      SZ_WORD: begin
        lane_data = wdata[WORD_W-1:0];
        lane_be   = '1;
      end
      default: begin
        lane_data = beat ? wdata[WORD_W-1:0] : wdata[2*WORD_W-1:WORD_W];
        lane_be   = '1;
      end
    endcase
  end
endmodule

// File: rtl/align_unit.sv
module align_unit
  import align_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned TTW     = 8,
  parameter logic [7:0]  TT_MISA = 8'h07
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fix_en,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [AW-1:0]       req_addr,
  input  logic [1:0]          req_size,
  input  logic [1:0]          req_kind,
  input  logic [63:0]         req_wdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [3:0]          mem_be,
  output logic [31:0]         mem_wdata,
  input  logic                mem_rvalid,
  input  logic [31:0]         mem_rdata,
  output logic                trap,
  output logic [TTW-1:0]      trap_type,
  output logic                res_valid,
  output logic [63:0]         res_data
);
  localparam logic [AW-1:0] STEP = AW'(LANES);

  seq_state_e          state;
  logic [AW-1:0]       addr_q;
  logic [OFS_W-1:0]    ofs_q;
  acc_size_e           size_q;
  acc_kind_e           kind_q;
  logic                two_q;
  logic                beat_q;
  logic [WORD_W-1:0]   w0_q;
  logic [2*WORD_W-1:0] wdata_q;
  logic                trap_q;
  logic [TTW-1:0]      tt_q;
  logic                rv_q;
  logic [2*WORD_W-1:0] rd_q;

  chk_res_t            chk;
  logic [WORD_W-1:0]   mw0;
  logic [2*WORD_W-1:0] merged;
  logic [AW-1:0]       xfer_tgt;

  align_check u_check (
    .addr_lo (req_addr[2:0]),
    .size    (acc_size_e'(req_size)),
    .kind    (acc_kind_e'(req_kind)),
    .fix_en  (fix_en),
    .res     (chk)
  );

  assign mw0 = (state == ST_BEAT0) ? mem_rdata : w0_q;

  align_merge u_merge (
    .w0   (mw0),
    .w1   (mem_rdata),
    .size (size_q),
    .ofs  (ofs_q),
    .data (merged)
  );

  align_lanes u_lanes (
    .wdata     (wdata_q),
    .size      (size_q),
    .ofs       (ofs_q),
    .beat      (beat_q),
    .lane_data (mem_wdata),
    .lane_be   (mem_be)
  );

  assign xfer_tgt = chk.misaligned ? {req_addr[AW-1:2], 2'b00} : req_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      ofs_q   <= '0;
      size_q  <= SZ_BYTE;
      kind_q  <= K_LOAD;
      two_q   <= 1'b0;
      beat_q  <= 1'b0;
      w0_q    <= '0;
      wdata_q <= '0;
      trap_q  <= 1'b0;
      tt_q    <= '0;
      rv_q    <= 1'b0;
      rd_q    <= '0;
    end else begin
      trap_q <= 1'b0;
      tt_q   <= '0;
      rv_q   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= {req_addr[AW-1:2], 2'b00};
            ofs_q   <= req_addr[OFS_W-1:0];
            size_q  <= acc_size_e'(req_size);
            kind_q  <= acc_kind_e'(req_kind);
            two_q   <= chk.two_beats;
            beat_q  <= 1'b0;
            wdata_q <= req_wdata;
            if (chk.misaligned && !chk.fixable) begin
              trap_q <= 1'b1;
              tt_q   <= TTW'(TT_MISA);
            end else if (!chk.uses_mem) begin
              state <= ST_DONE;
              rv_q  <= 1'b1;
              rd_q  <= {{(2*WORD_W-AW){1'b0}}, xfer_tgt};
            end else begin
              state <= ST_BEAT0;
            end
          end
        end
        ST_BEAT0: begin
          if (mem_rvalid) begin
            w0_q <= mem_rdata;
            if (two_q) begin
              state  <= ST_BEAT1;
              addr_q <= addr_q + STEP;
              beat_q <= 1'b1;
            end else begin
              state <= ST_DONE;
              rv_q  <= 1'b1;
              rd_q  <= (kind_q == K_STORE) ? '0 : merged;
            end
          end
        end
        ST_BEAT1: begin
          if (mem_rvalid) begin
            state <= ST_DONE;
            rv_q  <= 1'b1;
            rd_q  <= (kind_q == K_STORE) ? '0 : merged;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign mem_req   = (state == ST_BEAT0) || (state == ST_BEAT1);
  assign mem_we    = (kind_q == K_STORE);
  assign mem_addr  = addr_q;
  assign trap      = trap_q;
  assign trap_type = tt_q;
  assign res_valid = rv_q;
  assign res_data  = rd_q;
endmodule

// File: rtl/align_unit_chk.sv
module align_unit_chk #(
  parameter int unsigned AW  = 32,
  parameter int unsigned TTW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_ready,
  input logic           mem_req,
  input logic           mem_rvalid,
  input logic [AW-1:0]  mem_addr,
  input logic           trap,
  input logic [TTW-1:0] trap_type,
  input logic           res_valid
);
  p_trap_type_r3: assert property (@(posedge clk) disable iff (rst)
    trap |-> (trap_type == TTW'(8'h07)));

  p_trap_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
    trap |-> $past(req_valid && req_ready));

  p_trap_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    trap |-> (!mem_req && !res_valid));

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  p_res_single_r10: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> (!res_valid && req_ready));

  p_word_addr_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_next_word_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rvalid) |=> (!mem_req || (mem_addr == $past(mem_addr) + AW'(4))));

  p_hold_beat_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
endmodule

bind align_unit align_unit_chk #(.AW(AW), .TTW(TTW)) i_align_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .mem_req    (mem_req),
  .mem_rvalid (mem_rvalid),
  .mem_addr   (mem_addr),
  .trap       (trap),
  .trap_type  (trap_type),
  .res_valid  (res_valid)
);

// File: tb/test_align_unit.sv
module test_align_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fix_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [1:0]  req_kind = '0;
  logic [63:0] req_wdata = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        trap;
  logic [7:0]  trap_type;
  logic        res_valid;
  logic [63:0] res_data;

  always #10 clk = ~clk;

  align_unit i_align_unit (
    .clk(clk), .rst(rst), .fix_en(fix_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_kind(req_kind), .req_wdata(req_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .trap(trap), .trap_type(trap_type), .res_valid(res_valid), .res_data(res_data)
  );

  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;
  int          lat = 0;
  int          wait_cnt = 0;
  int          beat_count = 0;
  logic [31:0] beat_log [16];
  logic [31:0] mem [16];

  function automatic logic [31:0] init_word(input int i);
    if (i == 0) return 32'h12345678;
    if (i == 1) return 32'h9abcdef0;
    return 32'h0f1e2d3c + 32'(i) * 32'h11111111;
  endfunction

  function automatic logic [7:0] init_byte(input int a);
    logic [31:0] w;
    w = init_word(a / 4);
    return w[31 - 8*(a % 4) -: 8];
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst) begin
      for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
      wait_cnt <= 0;
    end else if (mem_req && !mem_rvalid) begin
      if (wait_cnt >= lat) begin
        wait_cnt   <= 0;
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[5:2]];
        beat_log[beat_count % 16] <= mem_addr;
        beat_count <= beat_count + 1;
        if (mem_we)
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  logic        r_trap, r_res;
  logic [7:0]  r_tt;
  logic [63:0] r_data;
  int          r_beats, r_start;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic op(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] kd,
                    input logic [63:0] wd, input logic fx);
    @(negedge clk);
    fix_en = fx; req_addr = a; req_size = sz; req_kind = kd; req_wdata = wd;
    req_valid = 1'b1;
    r_start = beat_count;
    @(negedge clk);
    req_valid = 1'b0;
    r_trap = 1'b0; r_res = 1'b0; r_tt = '0; r_data = '0;
    for (int i = 0; i < 40; i++) begin
      if (trap) begin r_trap = 1'b1; r_tt = trap_type; break; end
      if (res_valid) begin r_res = 1'b1; r_data = res_data; break; end
      @(negedge clk);
    end
    r_beats = beat_count - r_start;
  endtask

  task automatic t_reset();
    chk("R11 ready", 64'(req_ready), 64'd1);
    chk("R11 mem_req", 64'(mem_req), 64'd0);
    chk("R11 trap", 64'(trap), 64'd0);
    chk("R11 res_valid", 64'(res_valid), 64'd0);
  endtask

  task automatic t_aligned_loads();
    op(32'h0, 2'd2, 2'd0, '0, 1'b0);
    chk("R7 word data", r_data, 64'h12345678);
    chk("R7 word beats", 64'(r_beats), 64'd1);
    op(32'h2, 2'd0, 2'd0, '0, 1'b0);
    chk("R7 byte offset2", r_data, 64'h56);
    op(32'h6, 2'd1, 2'd0, '0, 1'b1);
    chk("R7 half offset2", r_data, 64'hdef0);
    op(32'h0, 2'd3, 2'd0, '0, 1'b0);
    chk("R8 dword data", r_data, 64'h123456789abcdef0);
    chk("R8 dword beats", 64'(r_beats), 64'd2);
    chk("R8 second addr", 64'(beat_log[(r_start + 1) % 16]), 64'h4);
  endtask

  task automatic t_traps();
    op(32'h1, 2'd2, 2'd0, '0, 1'b0);
    chk("R3 trap word fix off", 64'(r_trap), 64'd1);
    chk("R3 trap type", 64'(r_tt), 64'h07);
    chk("R3 no beat", 64'(r_beats), 64'd0);
    op(32'h3, 2'd1, 2'd0, '0, 1'b0);
    chk("R1 half odd traps", 64'(r_trap), 64'd1);
    op(32'h4, 2'd3, 2'd0, '0, 1'b0);
    chk("R1 dword at 4 traps", 64'(r_trap), 64'd1);
    op(32'h5, 2'd0, 2'd0, '0, 1'b0);
    chk("R1 byte never traps", 64'(r_trap), 64'd0);
    op(32'h2, 2'd1, 2'd0, '0, 1'b0);
    chk("R1 half at 2 ok", r_data, 64'h5678);
  endtask

  task automatic t_fixup_word();
    for (int k = 1; k < 4; k++) begin
      logic [31:0] e;
      op(32'(k), 2'd2, 2'd0, '0, 1'b1);
      e = {init_byte(k), init_byte(k + 1), init_byte(k + 2), init_byte(k + 3)};
      chk("R4 splice data", r_data, 64'(e));
      chk("R4 two beats", 64'(r_beats), 64'd2);
      chk("R4 first addr", 64'(beat_log[r_start % 16]), 64'h0);
      chk("R4 second addr", 64'(beat_log[(r_start + 1) % 16]), 64'h4);
      chk("R4 no trap", 64'(r_trap), 64'd0);
    end
    op(32'h1, 2'd2, 2'd0, '0, 1'b1);
    chk("R4 example", r_data, 64'h3456789a);
  endtask

  task automatic t_fixup_limits();
    op(32'h1, 2'd1, 2'd0, '0, 1'b1);
    chk("R6 half load traps", 64'(r_trap), 64'd1);
    op(32'h4, 2'd3, 2'd0, '0, 1'b1);
    chk("R6 dword load traps", 64'(r_trap), 64'd1);
    op(32'h21, 2'd2, 2'd1, 64'hffffffff, 1'b1);
    chk("R6 store traps", 64'(r_trap), 64'd1);
    chk("R6 store no beat", 64'(r_beats), 64'd0);
  endtask

  task automatic t_jumps();
    op(32'h102, 2'd2, 2'd2, '0, 1'b0);
    chk("R2 jump traps", 64'(r_trap), 64'd1);
    op(32'h101, 2'd0, 2'd3, '0, 1'b0);
    chk("R2 rett traps", 64'(r_trap), 64'd1);
    op(32'h100, 2'd0, 2'd2, '0, 1'b0);
    chk("R5 aligned target", r_data, 64'h100);
    op(32'h107, 2'd2, 2'd2, '0, 1'b1);
    chk("R5 forced target", r_data, 64'h104);
    chk("R5 no trap", 64'(r_trap), 64'd0);
    chk("R5 no beat", 64'(r_beats), 64'd0);
  endtask

  task automatic t_stores();
    op(32'h9, 2'd0, 2'd1, 64'h5a, 1'b0);
    chk("R9 store done", 64'(r_res), 64'd1);
    op(32'h9, 2'd0, 2'd0, '0, 1'b0);
    chk("R9 byte written", r_data, 64'h5a);
    op(32'h8, 2'd0, 2'd0, '0, 1'b0);
    chk("R9 neighbour kept", r_data, 64'(init_byte(8)));
    op(32'h1a, 2'd1, 2'd1, 64'hbeef, 1'b0);
    op(32'h18, 2'd2, 2'd0, '0, 1'b0);
    chk("R9 half lanes", r_data, 64'({init_byte(24), init_byte(25), 16'hbeef}));
    op(32'h10, 2'd3, 2'd1, 64'h0123456789abcdef, 1'b0);
    chk("R9 dword beats", 64'(r_beats), 64'd2);
    op(32'h10, 2'd2, 2'd0, '0, 1'b0);
    chk("R9 dword upper", r_data, 64'h01234567);
    op(32'h14, 2'd2, 2'd0, '0, 1'b0);
    chk("R9 dword lower", r_data, 64'h89abcdef);
  endtask

  task automatic t_busy();
    lat = 3;
    @(negedge clk);
    fix_en = 1'b1; req_addr = 32'h2; req_size = 2'd2; req_kind = 2'd0;
    req_valid = 1'b1;
    @(negedge clk);
    req_addr = 32'h20; req_size = 2'd2; req_kind = 2'd1; req_wdata = 64'hdeadbeef;
    for (int i = 0; i < 40; i++) begin
      if (res_valid) break;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R10 busy result", res_data, 64'h56789abc);
    @(negedge clk);
    chk("R10 strobe one cycle", 64'(res_valid), 64'd0);
    lat = 0;
    op(32'h20, 2'd2, 2'd0, '0, 1'b0);
    chk("R10 ignored store", r_data, 64'(init_word(8)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_aligned_loads();
    t_traps();
    t_fixup_word();
    t_fixup_limits();
    t_jumps();
    t_stores();
    t_busy();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule